// File: doc/BRIEF.md
# Indirect register access controller

This block lets a narrow, byte-wide host bus reach a register space that is wider in both address and data. The host never touches the internal registers directly. It stages a 16-bit target address and up to four bytes of write data in host-visible byte registers, then writes a command byte. The command byte carries a direction bit and a start bit. The controller runs exactly one transaction on an internal request/acknowledge port. When that transaction ends, the controller clears the start bit, which the host polls to learn that the transaction has finished.

Reads and writes take their target address from two separate byte-register pairs. A read and a write can therefore be staged back to back without reloading addresses. The 32-bit result of a read is kept in four read-data bytes until the next read completes. If the internal side never acknowledges, a timeout ends the transaction and raises a sticky error flag. The host clears that flag by writing a 1 to it.

Host map: 0x14A/0x14B write-address low/high; 0x14C command/status; 0x14D/0x14E read-address low/high; 0x150–0x153 write-data bytes 0–3; 0x154–0x157 read-data bytes 0–3; 0x158 error flag (bit 0). Data byte n holds internal data bits [8n+7:8n].

Top module: `ind_cmd_bridge`

## Requirements
- R1: After reset, every host register reads 0x00 and the internal request is low.
- R2: Writing 0x01 to 0x14C while idle issues one internal write (`reg_we`=1) using the write-address pair and the four write-data bytes. The request is held until `reg_ack`, drops after it, and command bit 0 then reads back 0.
- R3: Writing 0x03 to 0x14C while idle issues one internal read (`reg_we`=0). The acknowledged `reg_rdata` is captured, byte 0 of the read data at 0x154 and byte 3 at 0x157.
- R4: A read uses only the read-address pair (0x14D low, 0x14E high), and a write uses only the write-address pair (0x14A low, 0x14B high).
- R5: Command/status bit 0 reads 1 while a transaction is in flight. Bit 1 reads the direction of the last launched transaction (1 for a read, 0 for a write). Bits 7 to 2 always read 0.
- R6: A host write to 0x14C with bit 0 clear has no effect: no transaction starts and the register keeps its value.
- R7: While bit 0 of the command/status register is set, host writes to the address, write-data and command registers are ignored.
- R8: The read-data bytes change only when a read completes. A write transaction leaves them unchanged.
- R9: If no acknowledge arrives within TIMEOUT cycles of waiting, the request drops, bit 0 clears, the read data is left unchanged, and bit 0 at 0x158 is set. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R10: While the request is high, `reg_addr`, `reg_we` and `reg_wdata` stay stable, and one launch produces at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the current `host_addr` (combinational) |
| reg_req | output | 1 | Internal transaction request |
| reg_we | output | 1 | 1 = internal write, 0 = internal read |
| reg_addr | output | 16 | Internal target address |
| reg_wdata | output | 32 | Internal write data |
| reg_ack | input | 1 | Internal completion acknowledge, one cycle |
| reg_rdata | input | 32 | Internal read data, valid with `reg_ack` |

## Verification
The bench targets three kinds of error. The first is address-pair confusion: a read is launched right after the write address has been changed, so a design that shares or crosses the pairs drives the wrong `reg_addr`. The second is lockout during a busy transaction: address, data and command bytes are written while the start bit is set. A design without the lockout either retargets the live request or starts a second transaction, and the scoreboard rejects both. The bench also stalls the acknowledge to force a timeout, and then checks three things: the sticky flag and its write-1-to-clear behaviour, that the read data is left untouched, and that a later read completes normally.

// File: rtl/ind_pkg.sv
package ind_pkg;

    localparam int IADDR_W = 16;
    localparam int IDATA_W = 32;
    localparam int DBYTES  = IDATA_W / 8;
    localparam int HOST_AW = 12;

    localparam logic [HOST_AW-1:0] A_WADDR_LO = 12'h14A;
    localparam logic [HOST_AW-1:0] A_WADDR_HI = 12'h14B;
    localparam logic [HOST_AW-1:0] A_CMD      = 12'h14C;
    localparam logic [HOST_AW-1:0] A_RADDR_LO = 12'h14D;
    localparam logic [HOST_AW-1:0] A_RADDR_HI = 12'h14E;
    localparam logic [HOST_AW-1:0] A_WDATA0   = 12'h150;
    localparam logic [HOST_AW-1:0] A_RDATA0   = 12'h154;
    localparam logic [HOST_AW-1:0] A_ERR      = 12'h158;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 1;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic               rd;
        logic [IADDR_W-1:0] addr;
        logic [IDATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic lane_hit(input logic [HOST_AW-1:0] a,
                                      input logic [HOST_AW-1:0] base,
                                      input int lane);
        return a == (base + HOST_AW'(lane));
    endfunction

endpackage

// File: rtl/ind_host_regs.sv
module ind_host_regs
    import ind_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               seq_done,
    input  logic               seq_capture,
    input  logic               seq_err,
    input  logic [IDATA_W-1:0] cap_data,
    output logic               launch,
    output logic               busy,
    output xfer_t              xfer
);

    logic [IADDR_W-1:0]         waddr_q, raddr_q;
    logic                       dir_q, busy_q, err_q;
    logic [DBYTES-1:0][7:0]     wdata_q, rdata_q;
    logic                       wr_open;

    assign wr_open = host_wr && !busy_q;
    assign launch  = wr_open && (host_addr == A_CMD) && host_wdata[CMD_GO];
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr_q <= '0;
            raddr_q <= '0;
            dir_q   <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wr_open) begin
                case (host_addr)
                    A_WADDR_LO: waddr_q[7:0]  <= host_wdata;
                    A_WADDR_HI: waddr_q[15:8] <= host_wdata;
                    A_RADDR_LO: raddr_q[7:0]  <= host_wdata;
                    A_RADDR_HI: raddr_q[15:8] <= host_wdata;
                    default: ;
                endcase
            end
            if (launch) begin
                busy_q <= 1'b1;
                dir_q  <= host_wdata[CMD_DIR];
            end else if (seq_done) begin
                busy_q <= 1'b0;
            end
            if (seq_err)
                err_q <= 1'b1;
            else if (host_wr && host_addr == A_ERR && host_wdata[0])
                err_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < DBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                wdata_q[g] <= '0;
                rdata_q[g] <= '0;
            end else begin
                if (wr_open && lane_hit(host_addr, A_WDATA0, g))
                    wdata_q[g] <= host_wdata;
                if (seq_capture)
                    rdata_q[g] <= cap_data[8*g +: 8];
            end
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        case (host_addr)
            A_WADDR_LO: host_rdata = waddr_q[7:0];
            A_WADDR_HI: host_rdata = waddr_q[15:8];
            A_RADDR_LO: host_rdata = raddr_q[7:0];
            A_RADDR_HI: host_rdata = raddr_q[15:8];
            A_CMD:      host_rdata = {6'b0, dir_q, busy_q};
            A_ERR:      host_rdata = {7'b0, err_q};
            default: ;
        endcase
        for (int i = 0; i < DBYTES; i++) begin
            if (lane_hit(host_addr, A_WDATA0, i)) host_rdata = wdata_q[i];
            if (lane_hit(host_addr, A_RDATA0, i)) host_rdata = rdata_q[i];
        end
    end

    assign xfer.rd    = dir_q;
    assign xfer.addr  = dir_q ? raddr_q : waddr_q;
    assign xfer.wdata = wdata_q;

endmodule

// File: rtl/ind_seq.sv
module ind_seq
    import ind_pkg::*;
#(
    parameter int TIMEOUT = 255
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  launch,
    input  xfer_t xfer,
    input  logic  reg_ack,
    output logic  reg_req,
    output logic  reg_we,
    output logic  done,
    output logic  capture,
    output logic  err_set
);

    localparam int CW = $clog2(TIMEOUT + 1);

    seq_state_t      state_q;
    logic [CW-1:0]   cnt_q;
    logic            expired;

    assign expired = (cnt_q == CW'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (launch) state_q <= S_REQ;
                S_REQ: begin
                    cnt_q   <= '0;
                    state_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (reg_ack || expired) state_q <= S_DONE;
                    else                    cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign reg_req = (state_q == S_REQ) || (state_q == S_WAIT);
    assign reg_we  = !xfer.rd;
    assign done    = (state_q == S_DONE);
    assign capture = (state_q == S_WAIT) && reg_ack && xfer.rd;
    assign err_set = (state_q == S_WAIT) && !reg_ack && expired;

endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge
    import ind_pkg::*;
#(
    parameter int TIMEOUT = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               reg_req,
    output logic               reg_we,
    output logic [IADDR_W-1:0] reg_addr,
    output logic [IDATA_W-1:0] reg_wdata,
    input  logic               reg_ack,
    input  logic [IDATA_W-1:0] reg_rdata
);

    xfer_t xfer;
    logic  launch, busy, done, capture, err_set;

    ind_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .seq_done   (done),
        .seq_capture(capture),
        .seq_err    (err_set),
        .cap_data   (reg_rdata),
        .launch     (launch),
        .busy       (busy),
        .xfer       (xfer)
    );

    ind_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .xfer    (xfer),
        .reg_ack (reg_ack),
        .reg_req (reg_req),
        .reg_we  (reg_we),
        .done    (done),
        .capture (capture),
        .err_set (err_set)
    );

    assign reg_addr  = xfer.addr;
    assign reg_wdata = xfer.wdata;

endmodule

// File: rtl/ind_cmd_bridge_chk.sv
module ind_cmd_bridge_chk
    import ind_pkg::*;
#(
    parameter int TIMEOUT = 255
) (
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_go,
    input logic               reg_req,
    input logic               reg_ack,
    input logic               reg_we,
    input logic [IADDR_W-1:0] reg_addr,
    input logic [IDATA_W-1:0] reg_wdata,
    input logic               busy
);

    int run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= 0;
        else if (reg_req) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> !reg_req);

    a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
        (reg_req && $past(reg_req)) |-> ($stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    a_r2_release_after_ack: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_ack) |=> !reg_req);

    a_r6_launch_needs_go: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_req) |-> $past(host_wr && host_addr == A_CMD && host_go));

    a_r7_busy_covers_req: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> busy);

    a_r9_timeout_bound: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> (run_q <= TIMEOUT));

endmodule

bind ind_cmd_bridge ind_cmd_bridge_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_go   (host_wdata[0]),
    .reg_req   (reg_req),
    .reg_ack   (reg_ack),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy)
);

// File: tb/tb_ind_cmd_bridge.sv
module tb_ind_cmd_bridge;
    import ind_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               host_wr;
    logic [HOST_AW-1:0] host_addr;
    logic [7:0]         host_wdata;
    logic [7:0]         host_rdata;
    logic               reg_req, reg_we, reg_ack;
    logic [IADDR_W-1:0] reg_addr;
    logic [IDATA_W-1:0] reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    ind_cmd_bridge #(.TIMEOUT(255)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [31:0] data;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          ack_en = 1'b1;
    int          ack_lat = 0;
    int          lat_cnt = 0;
    logic [31:0] mem [0:255];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Internal register model
    always @(posedge clk) begin
        if (rst) begin
            reg_ack <= 1'b0;
            lat_cnt <= 0;
        end else begin
            reg_ack <= 1'b0;
            if (reg_req && !reg_ack && ack_en) begin
                if (lat_cnt >= ack_lat) begin
                    reg_ack <= 1'b1;
                    lat_cnt <= 0;
                    reg_rdata <= mem[reg_addr[7:0]];
                    if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end else begin
                lat_cnt <= 0;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && reg_req && reg_ack) begin
            if (sb_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6 R7 unexpected transaction actual addr=%h expected none", reg_addr);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R2 R3 direction", {31'b0, reg_we}, {31'b0, e.we});
                chk("R4 address pair", {16'b0, reg_addr}, {16'b0, e.addr});
                if (e.we) chk("R2 write data", reg_wdata, e.data);
            end
        end
    end

    task automatic hwrite(input logic [HOST_AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic hread(input logic [HOST_AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic read4(input logic [HOST_AW-1:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            hread(base + HOST_AW'(i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic set_pair(input logic [HOST_AW-1:0] lo, input logic [15:0] v);
        hwrite(lo, v[7:0]);
        hwrite(lo + 12'h001, v[15:8]);
    endtask

    task automatic set_wdata(input logic [31:0] v);
        for (int i = 0; i < 4; i++) hwrite(A_WDATA0 + HOST_AW'(i), v[8*i +: 8]);
    endtask

    task automatic wait_idle(input string req, input int limit);
        logic [7:0] d;
        int n = 0;
        do begin
            hread(A_CMD, d);
            n++;
        end while (d[0] && n < limit);
        chk(req, {31'b0, d[0]}, 32'h0);
    endtask

    task automatic push(input bit we, input logic [15:0] a, input logic [31:0] d);
        exp_t e;
        e.we = we; e.addr = a; e.data = d;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        for (int i = 0; i < 256; i++)
            mem[i] = {i[7:0], ~i[7:0], i[7:0], 8'h5A};
        rst = 1'b1; host_wr = 1'b0; host_addr = '0; host_wdata = '0; reg_rdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset values
        for (int a = 'h14A; a <= 'h158; a++) begin
            hread(HOST_AW'(a), b);
            chk("R1 reset value", {24'b0, b}, 32'h0);
        end
        chk("R1 request idle", {31'b0, reg_req}, 32'h0);

        // R2: write transaction
        ack_lat = 3;
        set_pair(A_WADDR_LO, 16'h1234);
        set_wdata(32'hA5A5_0F0F);
        push(1'b1, 16'h1234, 32'hA5A5_0F0F);
        hwrite(A_CMD, 8'h01);
        hread(A_CMD, b);
        chk("R5 busy during write", {24'b0, b}, 32'h01);
        wait_idle("R2 busy clears", 100);
        hread(A_CMD, b);
        chk("R5 after write", {24'b0, b}, 32'h00);

        // R3/R4: read uses read pair while write pair differs
        set_pair(A_RADDR_LO, 16'h1234);
        set_pair(A_WADDR_LO, 16'h5555);
        push(1'b0, 16'h1234, 32'h0);
        hwrite(A_CMD, 8'h03);
        hread(A_CMD, b);
        chk("R5 busy during read", {24'b0, b}, 32'h03);
        wait_idle("R3 busy clears", 100);
        read4(A_RDATA0, w);
        chk("R3 read data", w, 32'hA5A5_0F0F);
        hread(A_CMD, b);
        chk("R5 direction kept, upper bits zero", {24'b0, b}, 32'h02);

        // R6: command write with bit 0 clear
        hwrite(A_CMD, 8'h00);
        repeat (10) @(negedge clk);
        hread(A_CMD, b);
        chk("R6 no effect on command", {24'b0, b}, 32'h02);
        chk("R6 no request", {31'b0, reg_req}, 32'h0);

        // R7: lockout while busy
        ack_lat = 25;
        set_wdata(32'h1122_3344);
        push(1'b1, 16'h5555, 32'h1122_3344);
        hwrite(A_CMD, 8'h01);
        hwrite(A_WADDR_LO, 8'h77);
        hwrite(A_WDATA0, 8'hFF);
        hwrite(A_RADDR_HI, 8'hEE);
        hwrite(A_CMD, 8'h03);
        wait_idle("R7 busy clears", 100);
        hread(A_WADDR_LO, b);
        chk("R7 write address locked", {24'b0, b}, 32'h55);
        hread(A_WDATA0, b);
        chk("R7 write data locked", {24'b0, b}, 32'h44);
        hread(A_RADDR_HI, b);
        chk("R7 read address locked", {24'b0, b}, 32'h12);
        hread(A_CMD, b);
        chk("R7 command locked", {24'b0, b}, 32'h00);

        // R8: read data survives a write
        read4(A_RDATA0, w);
        chk("R8 read data kept", w, 32'hA5A5_0F0F);

        // R9: timeout
        ack_en = 1'b0;
        set_pair(A_RADDR_LO, 16'h0055);
        hwrite(A_CMD, 8'h03);
        wait_idle("R9 busy clears on timeout", 400);
        chk("R9 request dropped", {31'b0, reg_req}, 32'h0);
        hread(A_ERR, b);
        chk("R9 error set", {24'b0, b}, 32'h01);
        read4(A_RDATA0, w);
        chk("R9 read data unchanged", w, 32'hA5A5_0F0F);
        hwrite(A_ERR, 8'h00);
        hread(A_ERR, b);
        chk("R9 write 0 keeps error", {24'b0, b}, 32'h01);
        hwrite(A_ERR, 8'h01);
        hread(A_ERR, b);
        chk("R9 write 1 clears error", {24'b0, b}, 32'h00);

        // R3 again: recovery after timeout
        ack_en = 1'b1;
        ack_lat = 0;
        set_pair(A_RADDR_LO, 16'h5555);
        push(1'b0, 16'h5555, 32'h0);
        hwrite(A_CMD, 8'h03);
        wait_idle("R3 busy clears after recovery", 100);
        read4(A_RDATA0, w);
        chk("R3 read back written word", w, 32'h1122_3344);

        repeat (4) @(negedge clk);
        chk("R10 one request per launch", sb_q.size(), 32'h0);
        summary();
    end

endmodule